// File: doc/BRIEF.md
# Ping-Pong DMA Write Controller

This block moves data from an on-chip producer into host memory as a stream of memory-write packets. The host gives it two destination buffers. The block fills one buffer, and when that buffer is complete it moves straight on to the second one. It never waits for the host to handle an interrupt. Every packet carries a destination address and a byte length on its first beat, and payload words on every beat. A transaction-layer stub takes the packets through a valid/ready handshake.

The host programs the buffers through a small register port. A write to a base register loads the address and marks that buffer ready. When a buffer is complete, the block does four things in the same cycle: it raises an interrupt, records which buffer finished, releases that buffer and makes the other buffer active. Packets then carry the other buffer's address. While the block is filling one buffer, the host can load the next address into the idle register. The interrupt round trip on the host takes thousands of cycles, and this is how that time is hidden. If the buffer the block switches to has not been reloaded, the block stops and reports that it is starved. It does not send data to an old address.

The sequencer is a state machine with five states:
- `ST_IDLE`: after reset, waiting for buffer 0.
- `ST_STARVE`: after a switch, the new active buffer is not ready.
- `ST_WAIT_DATA`: waiting for the FIFO to hold the next packet's payload.
- `ST_SEND`: streaming beats.
- `ST_SWITCH`: one cycle of completion handling.

Its transitions are:
- IDLE→WAIT_DATA and STARVE→WAIT_DATA when the active buffer becomes ready.
- WAIT_DATA→SEND when enough words are queued.
- SEND→WAIT_DATA after a last beat that leaves room in the buffer.
- SEND→SWITCH after a last beat that fills the buffer.
- SWITCH→WAIT_DATA when the other buffer is ready.
- SWITCH→STARVE when it is not.

Top module: `pingpong_dma_wr`

## Requirements
- R1: After reset, `irq`, `starved`, `overflow` and `tlp_valid` are 0, `active_idx` is 0, and the buffer size is 512 bytes.
- R2: Host register map, written with `host_we`. `host_addr` 0 loads the buffer-0 base and sets its ready flag. `host_addr` 1 does the same for buffer 1. `host_addr` 2 loads the buffer size in bytes, which must be a nonzero multiple of 4. `host_addr` 3 is the control register: bit 0 = 1 acknowledges the interrupt, and bit 1 = 1 clears the overflow flag.
- R3: A write to a base register whose ready flag is set is ignored. The buffer in use keeps its address until it is released.
- R4: A packet's address is the active buffer's base plus the byte offset already written into that buffer. The offset grows by each packet's length and restarts at 0 in a new buffer.
- R5: A packet's length in bytes is the smaller of 128 and the bytes left in the buffer. A packet has length/4 beats of 32 bits. `tlp_sop` marks the first beat and `tlp_eop` marks the last.
- R6: A packet starts only when the FIFO holds all of its words. Payload words leave in the order the producer wrote them.
- R7: When a buffer's final beat is accepted, the block does the following with no host action:
  - sets `irq`;
  - sets `done_idx` to that buffer's index;
  - clears that buffer's ready flag;
  - makes the other buffer active, so the next packet uses the other base.
- R8: If the new active buffer is not ready after a switch, `starved` is 1 and `tlp_valid` stays 0, even while the FIFO holds data. Sending resumes when the host loads that buffer.
- R9: `irq` stays 1 until the host acknowledges it. A completion in the same cycle as an acknowledge keeps it at 1.
- R10: A producer write while `prod_full` is 1 drops the word and sets `overflow`. `overflow` stays 1 until the host clears it.
- R11: While `tlp_valid` is 1 and `tlp_ready` is 0, `tlp_valid`, `tlp_addr` and `tlp_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prod_valid | input | 1 | Producer writes one word |
| prod_data | input | DW | Producer word |
| prod_full | output | 1 | FIFO is full |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 32 | Host write data |
| tlp_valid | output | 1 | Packet beat valid |
| tlp_ready | input | 1 | Transaction layer accepts the beat |
| tlp_sop | output | 1 | First beat of a packet |
| tlp_eop | output | 1 | Last beat of a packet |
| tlp_addr | output | AW | Packet destination byte address |
| tlp_len | output | LW | Packet length in bytes |
| tlp_data | output | DW | Payload word |
| irq | output | 1 | Buffer-complete interrupt request |
| done_idx | output | 1 | Index of the last completed buffer |
| active_idx | output | 1 | Index of the buffer being filled |
| starved | output | 1 | Stalled: active buffer not ready |
| overflow | output | 1 | Sticky producer-overflow flag |

## Verification
The hardest condition to reach is a switch into a buffer that the host has not reloaded. The interrupt must stay held while the outgoing stream keeps its address discipline, and this needs the producer, the host and the sink to line up in time. The bench sweeps a set of buffer sizes, including sizes that split into a full and a short packet and a one-word buffer. For each size it releases only one buffer's worth of producer data at a time. This places every completion at a known point, so the interrupt and buffer index can be checked before acknowledging. After the second buffer of each sweep, both buffers are spent, so the block necessarily enters the starved state. The sink applies a repeating back-pressure pattern, so every packet boundary meets stalled beats. The ignored reload and the overflow are both observed through the packet addresses and the status pins.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

    localparam int HOST_W = 32;

    // host register selects
    localparam logic [1:0] REG_BASE0 = 2'd0;
    localparam logic [1:0] REG_BASE1 = 2'd1;
    localparam logic [1:0] REG_SIZE  = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    // control register bits
    localparam int CTRL_ACK_BIT     = 0;
    localparam int CTRL_CLR_OVF_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STARVE,
        ST_WAIT_DATA,
        ST_SEND,
        ST_SWITCH
    } seq_state_t;

endpackage

// File: rtl/pp_word_fifo.sv
module pp_word_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          wr_drop
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic          do_wr;
    logic          do_rd;

    assign full    = (count == CW'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && (count != '0);
    assign wr_drop = wr_en && full;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_rd) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pp_addr_bank.sv
module pp_addr_bank
    import pp_dma_pkg::*;
#(
    parameter int AW       = 32,
    parameter int SIZE_W   = 16,
    parameter int DEF_SIZE = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              release_en,
    input  logic              release_idx,
    output logic [AW-1:0]     base [2],
    output logic [1:0]        ready,
    output logic [SIZE_W-1:0] buf_size
);

    for (genvar i = 0; i < 2; i++) begin : g_slot
        logic load_hit;
        // a slot accepts a new address only while it is released
        assign load_hit = host_we && (host_addr == 2'(i)) && !ready[i];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base[i]  <= '0;
                ready[i] <= 1'b0;
            end else if (load_hit) begin
                base[i]  <= host_wdata[AW-1:0];
                ready[i] <= 1'b1;
            end else if (release_en && (release_idx == 1'(i))) begin
                ready[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_size <= SIZE_W'(DEF_SIZE);
        end else if (host_we && host_addr == REG_SIZE) begin
            buf_size <= host_wdata[SIZE_W-1:0];
        end
    end

endmodule

// File: rtl/pp_irq_status.sv
module pp_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic done_pulse,
    input  logic done_idx_in,
    input  logic ack,
    input  logic ovf_set,
    input  logic ovf_clr,
    output logic irq,
    output logic done_idx,
    output logic overflow
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq      <= 1'b0;
            done_idx <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (done_pulse) begin
                irq      <= 1'b1;
                done_idx <= done_idx_in;
            end else if (ack) begin
                irq <= 1'b0;
            end
            if (ovf_set) begin
                overflow <= 1'b1;
            end else if (ovf_clr) begin
                overflow <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pp_wr_seq.sv
module pp_wr_seq
    import pp_dma_pkg::*;
#(
    parameter int AW            = 32,
    parameter int DW            = 32,
    parameter int SIZE_W        = 16,
    parameter int PAYLOAD_BYTES = 128,
    parameter int CW            = 7,
    localparam int LW           = $clog2(PAYLOAD_BYTES + 1),
    localparam int BSH          = $clog2(DW / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     base [2],
    input  logic [1:0]        ready,
    input  logic [SIZE_W-1:0] buf_size,
    input  logic [CW-1:0]     fifo_count,
    input  logic [DW-1:0]     fifo_data,
    output logic              fifo_pop,
    input  logic              tlp_ready,
    output logic              tlp_valid,
    output logic              tlp_sop,
    output logic              tlp_eop,
    output logic [AW-1:0]     tlp_addr,
    output logic [LW-1:0]     tlp_len,
    output logic [DW-1:0]     tlp_data,
    output logic              done_pulse,
    output logic              active_idx,
    output logic              starved
);

    seq_state_t        state;
    seq_state_t        state_n;
    logic              act;
    logic [SIZE_W-1:0] offset;
    logic [LW-1:0]     cur_len;
    logic [LW-1:0]     beat;

    logic [SIZE_W-1:0] remain;
    logic [LW-1:0]     nxt_len;
    logic [LW-1:0]     nxt_words;
    logic [LW-1:0]     cur_words;
    logic [SIZE_W-1:0] offset_sum;
    logic              go;
    logic              accept;
    logic              last;

    assign remain     = buf_size - offset;
    assign nxt_len    = (remain > SIZE_W'(PAYLOAD_BYTES)) ? LW'(PAYLOAD_BYTES) : LW'(remain);
    assign nxt_words  = nxt_len >> BSH;
    assign cur_words  = cur_len >> BSH;
    assign offset_sum = offset + SIZE_W'(cur_len);
    assign go         = (fifo_count >= CW'(nxt_words));
    assign accept     = (state == ST_SEND) && tlp_ready;
    assign last       = (beat == cur_words - 1'b1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE, ST_STARVE: begin
                if (ready[act]) state_n = ST_WAIT_DATA;
            end
            ST_WAIT_DATA: begin
                if (go) state_n = ST_SEND;
            end
            ST_SEND: begin
                if (accept && last) begin
                    state_n = (offset_sum >= buf_size) ? ST_SWITCH : ST_WAIT_DATA;
                end
            end
            ST_SWITCH: begin
                state_n = ready[~act] ? ST_WAIT_DATA : ST_STARVE;
            end
        endcase
    end

    // datapath registers: active slot, buffer offset, packet length, beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act     <= 1'b0;
            offset  <= '0;
            cur_len <= '0;
            beat    <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_STARVE: begin
                    beat <= '0;
                end
                ST_WAIT_DATA: begin
                    if (go) begin
                        cur_len <= nxt_len;
                        beat    <= '0;
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        if (last) begin
                            beat   <= '0;
                            offset <= offset_sum;
                        end else begin
                            beat <= beat + 1'b1;
                        end
                    end
                end
                ST_SWITCH: begin
                    act    <= ~act;
                    offset <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        tlp_valid  = (state == ST_SEND);
        tlp_sop    = (state == ST_SEND) && (beat == '0);
        tlp_eop    = (state == ST_SEND) && last;
        tlp_addr   = base[act] + AW'(offset);
        tlp_len    = cur_len;
        tlp_data   = fifo_data;
        fifo_pop   = accept;
        done_pulse = (state == ST_SWITCH);
        starved    = (state == ST_STARVE);
        active_idx = act;
    end

endmodule

// File: rtl/pingpong_dma_wr.sv
module pingpong_dma_wr
    import pp_dma_pkg::*;
#(
    parameter int AW            = 32,
    parameter int DW            = 32,
    parameter int FIFO_DEPTH    = 64,
    parameter int PAYLOAD_BYTES = 128,
    parameter int SIZE_W        = 16,
    parameter int DEF_SIZE      = 512,
    localparam int LW           = $clog2(PAYLOAD_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prod_valid,
    input  logic [DW-1:0]     prod_data,
    output logic              prod_full,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic              tlp_valid,
    input  logic              tlp_ready,
    output logic              tlp_sop,
    output logic              tlp_eop,
    output logic [AW-1:0]     tlp_addr,
    output logic [LW-1:0]     tlp_len,
    output logic [DW-1:0]     tlp_data,
    output logic              irq,
    output logic              done_idx,
    output logic              active_idx,
    output logic              starved,
    output logic              overflow
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [DW-1:0]     fifo_head;
    logic [CW-1:0]     fifo_count;
    logic              fifo_pop;
    logic              wr_drop;
    logic [AW-1:0]     base [2];
    logic [1:0]        ready;
    logic [SIZE_W-1:0] buf_size;
    logic              done_pulse;
    logic              ctrl_wr;

    assign ctrl_wr = host_we && (host_addr == REG_CTRL);

    pp_word_fifo #(
        .DW    (DW),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prod_valid),
        .wr_data (prod_data),
        .rd_en   (fifo_pop),
        .rd_data (fifo_head),
        .count   (fifo_count),
        .full    (prod_full),
        .wr_drop (wr_drop)
    );

    pp_addr_bank #(
        .AW       (AW),
        .SIZE_W   (SIZE_W),
        .DEF_SIZE (DEF_SIZE)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .release_en  (done_pulse),
        .release_idx (active_idx),
        .base        (base),
        .ready       (ready),
        .buf_size    (buf_size)
    );

    pp_wr_seq #(
        .AW            (AW),
        .DW            (DW),
        .SIZE_W        (SIZE_W),
        .PAYLOAD_BYTES (PAYLOAD_BYTES),
        .CW            (CW)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .base       (base),
        .ready      (ready),
        .buf_size   (buf_size),
        .fifo_count (fifo_count),
        .fifo_data  (fifo_head),
        .fifo_pop   (fifo_pop),
        .tlp_ready  (tlp_ready),
        .tlp_valid  (tlp_valid),
        .tlp_sop    (tlp_sop),
        .tlp_eop    (tlp_eop),
        .tlp_addr   (tlp_addr),
        .tlp_len    (tlp_len),
        .tlp_data   (tlp_data),
        .done_pulse (done_pulse),
        .active_idx (active_idx),
        .starved    (starved)
    );

    pp_irq_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_pulse  (done_pulse),
        .done_idx_in (active_idx),
        .ack         (ctrl_wr && host_wdata[CTRL_ACK_BIT]),
        .ovf_set     (wr_drop),
        .ovf_clr     (ctrl_wr && host_wdata[CTRL_CLR_OVF_BIT]),
        .irq         (irq),
        .done_idx    (done_idx),
        .overflow    (overflow)
    );

endmodule

// File: rtl/pp_dma_checker.sv
module pp_dma_checker
    import pp_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 8,
    parameter int PAYLOAD_BYTES = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [1:0]        host_addr,
    input logic [HOST_W-1:0] host_wdata,
    input logic              tlp_valid,
    input logic              tlp_ready,
    input logic              tlp_sop,
    input logic [AW-1:0]     tlp_addr,
    input logic [LW-1:0]     tlp_len,
    input logic [DW-1:0]     tlp_data,
    input logic              irq,
    input logic              overflow,
    input logic              starved
);

    logic ack_wr;
    logic clr_wr;
    assign ack_wr = host_we && host_addr == REG_CTRL && host_wdata[CTRL_ACK_BIT];
    assign clr_wr = host_we && host_addr == REG_CTRL && host_wdata[CTRL_CLR_OVF_BIT];

    assert_hold_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tlp_valid && !tlp_ready |=> tlp_valid && $stable(tlp_data) && $stable(tlp_addr));

    assert_no_send_starved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        starved |-> !tlp_valid);

    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack_wr |=> irq);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !clr_wr |=> overflow);

    assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tlp_valid && tlp_sop |-> (tlp_len != '0) && (tlp_len <= LW'(PAYLOAD_BYTES)));

    assert_len_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tlp_valid |-> tlp_len[1:0] == 2'b00);

endmodule

bind pingpong_dma_wr pp_dma_checker #(
    .AW            (AW),
    .DW            (DW),
    .LW            (LW),
    .PAYLOAD_BYTES (PAYLOAD_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .tlp_valid  (tlp_valid),
    .tlp_ready  (tlp_ready),
    .tlp_sop    (tlp_sop),
    .tlp_addr   (tlp_addr),
    .tlp_len    (tlp_len),
    .tlp_data   (tlp_data),
    .irq        (irq),
    .overflow   (overflow),
    .starved    (starved)
);

// File: tb/tb_pingpong_dma_wr.sv
module tb_pingpong_dma_wr;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prod_valid = 1'b0;
    logic [DW-1:0] prod_data = '0;
    logic          prod_full;
    logic          host_we = 1'b0;
    logic [1:0]    host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic          tlp_valid;
    logic          tlp_ready = 1'b0;
    logic          tlp_sop;
    logic          tlp_eop;
    logic [AW-1:0] tlp_addr;
    logic [LW-1:0] tlp_len;
    logic [DW-1:0] tlp_data;
    logic          irq;
    logic          done_idx;
    logic          active_idx;
    logic          starved;
    logic          overflow;

    always #2.5 clk = ~clk;

    pingpong_dma_wr dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_valid (prod_valid),
        .prod_data  (prod_data),
        .prod_full  (prod_full),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .tlp_valid  (tlp_valid),
        .tlp_ready  (tlp_ready),
        .tlp_sop    (tlp_sop),
        .tlp_eop    (tlp_eop),
        .tlp_addr   (tlp_addr),
        .tlp_len    (tlp_len),
        .tlp_data   (tlp_data),
        .irq        (irq),
        .done_idx   (done_idx),
        .active_idx (active_idx),
        .starved    (starved),
        .overflow   (overflow)
    );

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    // bench model
    logic [31:0] exp_base [2];
    bit          exp_rdy  [2];
    int          exp_buf  = 0;
    int          exp_off  = 0;
    int          exp_size = 512;
    int          exp_word = 0;
    int          bufs_done = 0;
    int          beat_i   = 0;
    int          pkt_len  = 0;

    int          push_target = 0;
    int          pushed      = 0;
    bit          ignore_full = 0;
    bit          bp_on       = 1;
    int          cyc         = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_we = 1'b0;
    endtask

    // R2/R3 model: base accepted only while released
    task automatic prog_base(input int idx, input logic [31:0] val);
        if (!exp_rdy[idx]) begin
            exp_base[idx] = val;
            exp_rdy[idx]  = 1;
        end
        host_write(2'(idx), val);
    endtask

    // producer stub
    always @(posedge clk) begin
        #1;
        if (rst_n && pushed < push_target && (ignore_full || !prod_full)) begin
            prod_valid = 1'b1;
            prod_data  = DW'(pushed);
            pushed++;
        end else begin
            prod_valid = 1'b0;
        end
    end

    // transaction-layer stub with periodic back-pressure
    always @(posedge clk) begin
        #1;
        cyc++;
        tlp_ready = bp_on ? (cyc % 3 != 0) : 1'b1;
    end

    // packet monitor: accepted beats observed at the falling edge
    always @(negedge clk) begin
        if (rst_n && tlp_valid && tlp_ready) begin
            if (beat_i == 0) begin
                pkt_len = (exp_size - exp_off > 128) ? 128 : exp_size - exp_off;
                chk(tlp_sop == 1'b1, "R5 sop", tlp_sop, 1);
                chk(tlp_addr == exp_base[exp_buf] + 32'(exp_off), "R4 addr",
                    tlp_addr, exp_base[exp_buf] + 32'(exp_off));
                chk(int'(tlp_len) == pkt_len, "R5 len", tlp_len, pkt_len);
            end
            chk(tlp_data == DW'(exp_word), "R6 data order", tlp_data, exp_word);
            exp_word++;
            chk(tlp_eop == (beat_i == pkt_len / 4 - 1), "R5 eop", tlp_eop, beat_i == pkt_len / 4 - 1);
            if (beat_i == pkt_len / 4 - 1) begin
                beat_i = 0;
                exp_off += pkt_len;
                if (exp_off >= exp_size) begin
                    exp_rdy[exp_buf] = 0;
                    exp_buf ^= 1;
                    exp_off = 0;
                    bufs_done++;
                end
            end else begin
                beat_i++;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", bufs_done, -1);
        finish_run();
    end

    int sizes [6] = '{128, 192, 320, 4, 132, 256};

    initial begin
        exp_base[0] = '0; exp_base[1] = '0;
        exp_rdy[0] = 0;   exp_rdy[1] = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(irq == 0,        "R1 irq",      irq, 0);
        chk(starved == 0,    "R1 starved",  starved, 0);
        chk(overflow == 0,   "R1 overflow", overflow, 0);
        chk(tlp_valid == 0,  "R1 valid",    tlp_valid, 0);
        chk(active_idx == 0, "R1 active",   active_idx, 0);

        for (int k = 0; k < 6; k++) begin
            int sz;
            sz = sizes[k];
            exp_size = sz;
            host_write(2'd2, 32'(sz));
            prog_base(0, 32'h1000_0000 | (32'(k) << 16));
            prog_base(1, 32'h2000_0000 | (32'(k) << 16) | 32'h0000_8000);
            if (k == 0) begin
                // R3: buffer 0 already ready, reload must be ignored
                prog_base(0, 32'hDEAD_0000);
            end
            if (sz >= 128) begin
                push_target += 31;
                repeat (45) @(posedge clk);
                @(negedge clk);
                chk(tlp_valid == 0, "R6 waits for full payload", tlp_valid, 0);
                push_target += sz / 4 - 31;
            end else begin
                push_target += sz / 4;
            end
            wait (bufs_done == 2 * k + 1);
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(irq == 1,        "R7 irq raised",  irq, 1);
            chk(done_idx == 0,   "R7 done_idx",    done_idx, 0);
            chk(active_idx == 1, "R7 switched",    active_idx, 1);
            chk(starved == 0,    "R8 not starved", starved, 0);
            repeat (10) @(posedge clk);
            @(negedge clk);
            chk(irq == 1, "R9 irq held", irq, 1);
            host_write(2'd3, 32'h1);
            @(negedge clk);
            chk(irq == 0, "R9 ack clears", irq, 0);

            push_target += sz / 4;
            wait (bufs_done == 2 * k + 2);
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(irq == 1,        "R7 irq raised 2", irq, 1);
            chk(done_idx == 1,   "R7 done_idx 2",   done_idx, 1);
            chk(active_idx == 0, "R7 switched 2",   active_idx, 0);
            chk(starved == 1,    "R8 starved",      starved, 1);
            chk(overflow == 0,   "R10 no overflow", overflow, 0);
            host_write(2'd3, 32'h1);
        end

        // R8: data waiting but no ready buffer
        push_target += 5;
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(tlp_valid == 0, "R8 no send while starved", tlp_valid, 0);
        chk(starved == 1,   "R8 starved held",          starved, 1);

        // R10: overflow and clear
        ignore_full = 1;
        push_target += 70;
        wait (pushed == push_target);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(prod_full == 1, "R10 full",         prod_full, 1);
        chk(overflow == 1,  "R10 overflow set", overflow, 1);
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(overflow == 1,  "R10 overflow sticky", overflow, 1);
        host_write(2'd3, 32'h2);
        @(negedge clk);
        chk(overflow == 0,  "R10 overflow cleared", overflow, 0);
        chk(prod_full == 1, "R10 data kept",        prod_full, 1);

        finish_run();
    end

endmodule